// File: doc/BRIEF.md
# Self-Synchronous Octet Scrambler

This block whitens a byte stream one octet per clock with the self-synchronizing polynomial 1 + x^14 + x^15, ahead of line coding in a serial transmit path. All eight bits of an octet are handled in parallel in a single cycle, in the order most significant bit first. Each output bit is the input bit XOR the two scrambled bits that left the block 14 and 15 bit positions earlier. A 15-bit history of scrambled bits carries over from one octet to the next. Each lane of a link uses its own instance.

The same datapath runs as the receive-side descrambler when the direction control is set. In that mode the history is filled with the received scrambled bits rather than with the output bits. Because of this the descrambler locks onto any incoming stream within 15 bits, whatever its starting history. When the scramble enable is low, octets pass through unchanged and the history stays frozen. The output is registered, and the valid flag travels with the data.

Top module: `ss_octet_scrambler`

## Requirements
- R1: While reset is held and after reset, out_valid is 0 and out_data is 0x00, and the history register holds all ones (every history bit reads as 1 for the first scrambled bits).
- R2: out_valid equals in_valid delayed by exactly one clock, and out_data belongs to the octet presented on the same edge.
- R3: With scr_en=1 and descr_mode=0, the bits of each octet are handled in the order in_data[7] first, in_data[0] last. Each output bit is the input bit XOR the scrambled output bits 14 and 15 positions earlier in that serial order, and the history advances by 8 scrambled bits for each valid octet.
- R4: With scr_en=0, a valid octet appears unchanged on out_data and the history is not touched. The next scrambled octet is computed as if the bypassed octets had never been sent.
- R5: A cycle with in_valid=0 does not advance the history, and out_data keeps its previous value.
- R6: With scr_en=1 and descr_mode=1, each output bit is the received bit XOR the received bits 14 and 15 positions earlier, and the history is fed with the received bits.
- R7: A scrambled stream fed back through descrambler mode returns the original octets exactly when both sides start from reset. From any other starting history, every bit from the 16th received bit onward is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | in_data holds an octet this cycle |
| in_data | input | 8 | Octet in; bit 7 is handled first |
| scr_en | input | 1 | 1 = scramble or descramble, 0 = pass through |
| descr_mode | input | 1 | 0 = scrambler, 1 = descrambler |
| out_valid | output | 1 | out_data holds a processed octet |
| out_data | output | 8 | Processed octet, one cycle after its input |

## Verification
The assertions rely on three things about the inputs: they are stable across each rising edge, in_valid and the mode controls are never unknown once reset is released, and in_data carries a meaningful value whenever in_valid is high. The bench changes every input only on the falling clock edge and always drives known values, including on idle cycles. Direction and enable may change between any two octets, and both the bypass and the idle properties are checked against such switches.

// File: rtl/ss_scr_pkg.sv
// Package: shared defaults and the operating-mode type for the octet
// scrambler. Assumes a history no narrower than the far tap.
package ss_scr_pkg;

    localparam int unsigned SCR_DATA_W   = 8;
    localparam int unsigned SCR_HIST_W   = 15;
    localparam int unsigned SCR_TAP_NEAR = 14;
    localparam int unsigned SCR_TAP_FAR  = 15;

    typedef enum logic [1:0] {
        SCR_MODE_PASS      = 2'd0,
        SCR_MODE_SCRAMBLE  = 2'd1,
        SCR_MODE_DESCRAMBLE = 2'd2
    } scr_mode_e;

endpackage

// File: rtl/ss_scr_mode_dec.sv
// Module: ss_scr_mode_dec
// Turns the enable and direction controls into one operating mode and
// produces the strobe that lets the history advance. Assumes the
// controls are valid whenever in_valid is high.
module ss_scr_mode_dec
    import ss_scr_pkg::*;
(
    input  logic      in_valid,
    input  logic      scr_en,
    input  logic      descr_mode,
    output scr_mode_e mode,
    output logic      advance
);

    // Select the mode; bypass wins over direction.
    always_comb begin
        if (!scr_en) begin
            mode = SCR_MODE_PASS;
        end else if (descr_mode) begin
            mode = SCR_MODE_DESCRAMBLE;
        end else begin
            mode = SCR_MODE_SCRAMBLE;
        end
    end

    // History moves only for valid octets outside bypass.
    always_comb begin
        advance = in_valid && (mode != SCR_MODE_PASS);
    end

endmodule

// File: rtl/ss_scr_tap_net.sv
// Module: ss_scr_tap_net
// Combinational unrolling of the bit-serial self-synchronizing
// recurrence over one word. hist[0] is the newest history bit and
// hist[k] the bit k+1 positions back. The word's MSB goes first.
// Assumes DATA_W and both taps fit inside the history width.
module ss_scr_tap_net #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HIST_W   = 15,
    parameter int unsigned TAP_NEAR = 14,
    parameter int unsigned TAP_FAR  = 15
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [DATA_W-1:0] word_in,
    input  logic              feed_input,
    output logic [DATA_W-1:0] word_out,
    output logic [HIST_W-1:0] hist_next
);

    localparam int unsigned NEAR_IDX = TAP_NEAR - 1;
    localparam int unsigned FAR_IDX  = TAP_FAR - 1;

    // Walk the bits in serial order, shifting each new history bit in.
    always_comb begin
        logic [HIST_W-1:0] h;
        logic              b;
        logic              o;
        h        = hist;
        word_out = '0;
        for (int i = 0; i < int'(DATA_W); i++) begin
            b = word_in[DATA_W-1-i];
            o = b ^ h[NEAR_IDX] ^ h[FAR_IDX];
            word_out[DATA_W-1-i] = o;
            h = {h[HIST_W-2:0], (feed_input ? b : o)};
        end
        hist_next = h;
    end

endmodule

// File: rtl/ss_scr_history.sv
// Module: ss_scr_history
// Holds the scrambled-bit history. Loads SEED on reset and takes the
// next value only when advance is high. Synchronous, active-low reset.
module ss_scr_history #(
    parameter int unsigned     HIST_W = 15,
    parameter logic [HIST_W-1:0] SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [HIST_W-1:0] hist_next,
    output logic [HIST_W-1:0] hist
);

    // Seed on reset, otherwise step on each advancing octet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= SEED;
        end else if (advance) begin
            hist <= hist_next;
        end
    end

endmodule

// File: rtl/ss_scr_out_stage.sv
// Module: ss_scr_out_stage
// Output register. Picks the raw or processed word by mode, moves the
// valid flag through, and keeps the data when no word is valid.
module ss_scr_out_stage
    import ss_scr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scr_mode_e         mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] raw_word,
    input  logic [DATA_W-1:0] proc_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] sel_word;

    // Bypass uses the raw word; both other modes use the tap network.
    always_comb begin
        sel_word = (mode == SCR_MODE_PASS) ? raw_word : proc_word;
    end

    // Register the valid flag every cycle and the data on valid only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= sel_word;
            end
        end
    end

endmodule

// File: rtl/ss_octet_scrambler.sv
// Module: ss_octet_scrambler
// Top level: a self-synchronizing parallel scrambler/descrambler with
// bypass, one word per clock and one cycle of latency. One instance
// per lane. The inputs are assumed synchronous to clk.
module ss_octet_scrambler
    import ss_scr_pkg::*;
#(
    parameter int unsigned DATA_W   = SCR_DATA_W,
    parameter int unsigned HIST_W   = SCR_HIST_W,
    parameter int unsigned TAP_NEAR = SCR_TAP_NEAR,
    parameter int unsigned TAP_FAR  = SCR_TAP_FAR,
    parameter logic [HIST_W-1:0] SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              scr_en,
    input  logic              descr_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    scr_mode_e         mode;
    logic              advance;
    logic              feed_input;
    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] hist_next;
    logic [DATA_W-1:0] proc_word;

    ss_scr_mode_dec u_mode (
        .in_valid   (in_valid),
        .scr_en     (scr_en),
        .descr_mode (descr_mode),
        .mode       (mode),
        .advance    (advance)
    );

    // The receive side feeds its history with the incoming bits.
    always_comb begin
        feed_input = (mode == SCR_MODE_DESCRAMBLE);
    end

    ss_scr_tap_net #(
        .DATA_W   (DATA_W),
        .HIST_W   (HIST_W),
        .TAP_NEAR (TAP_NEAR),
        .TAP_FAR  (TAP_FAR)
    ) u_taps (
        .hist       (hist),
        .word_in    (in_data),
        .feed_input (feed_input),
        .word_out   (proc_word),
        .hist_next  (hist_next)
    );

    ss_scr_history #(
        .HIST_W (HIST_W),
        .SEED   (SEED)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .hist_next (hist_next),
        .hist      (hist)
    );

    ss_scr_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .in_valid  (in_valid),
        .raw_word  (in_data),
        .proc_word (proc_word),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/ss_octet_scrambler_chk.sv
// Module: ss_octet_scrambler_chk
// Port-level protocol checks for the scrambler, attached by bind.
module ss_octet_scrambler_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              scr_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    // R2: a valid input gives a valid output on the next cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: an idle input gives an idle output on the next cycle.
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: a bypassed octet comes out unchanged.
    assert_bypass_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scr_en) |=> (out_data == $past(in_data)));

    // R5: the output data holds across idle cycles.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

endmodule

bind ss_octet_scrambler ss_octet_scrambler_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .scr_en    (scr_en),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/ss_octet_scrambler_bench.sv
// Bench: directed scenarios against a bit-serial reference model.
module ss_octet_scrambler_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       scr_en = 1'b0;
    logic       descr_mode = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;

    logic [14:0] mhist = 15'h7FFF;
    logic [7:0]  last_out = 8'h00;
    logic [7:0]  orig [0:11];
    logic [7:0]  cap  [0:11];

    always #2.5 clk = ~clk;

    ss_octet_scrambler u_ss_octet_scrambler (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .scr_en     (scr_en),
        .descr_mode (descr_mode),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Serial reference: MSB first, taps at 14 and 15 bits back.
    function automatic logic [7:0] model(input logic [7:0] d, input logic en, input logic dm);
        logic [7:0] r;
        logic o;
        if (!en) return d;
        r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            o = d[i] ^ mhist[13] ^ mhist[14];
            r[i] = o;
            mhist = {mhist[13:0], (dm ? d[i] : o)};
        end
        return r;
    endfunction

    // One cycle: drive at falling edge, sample just after the rising edge.
    task automatic step(input string req, input logic v, input logic [7:0] d,
                        input logic en, input logic dm, output logic [7:0] got);
        logic [7:0] exp;
        @(negedge clk);
        in_valid = v; in_data = d; scr_en = en; descr_mode = dm;
        exp = v ? model(d, en, dm) : last_out;
        @(posedge clk); #1;
        check(req, {31'd0, out_valid}, {31'd0, v});
        check(req, {24'd0, out_data}, {24'd0, exp});
        last_out = exp;
        got = out_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; scr_en = 1'b0; descr_mode = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset data", {24'd0, out_data}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mhist = 15'h7FFF;
        last_out = 8'h00;
    endtask

    // R1/R3: all-zero input right after reset exposes the all-ones seed.
    task automatic t_seed_r1();
        logic [7:0] g;
        do_reset();
        step("R1 seed", 1'b1, 8'h00, 1'b1, 1'b0, g);
        check("R1 first octet", {24'd0, g}, 32'h00);
        step("R3 zeros", 1'b1, 8'h00, 1'b1, 1'b0, g);
    endtask

    // R3/R2: back-to-back scrambling of varied patterns.
    task automatic t_scramble_r3();
        logic [7:0] g;
        logic [7:0] pat [0:7] = '{8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'h7E, 8'hC3};
        do_reset();
        for (int i = 0; i < 8; i++) step("R3 scramble", 1'b1, pat[i], 1'b1, 1'b0, g);
    endtask

    // R5: idle cycles hold output and leave history untouched.
    task automatic t_idle_r5();
        logic [7:0] g;
        do_reset();
        step("R3 before idle", 1'b1, 8'h96, 1'b1, 1'b0, g);
        step("R5 idle", 1'b0, 8'hFF, 1'b1, 1'b0, g);
        step("R5 idle", 1'b0, 8'h12, 1'b1, 1'b1, g);
        step("R5 after idle", 1'b1, 8'h96, 1'b1, 1'b0, g);
        step("R5 after idle", 1'b1, 8'h44, 1'b1, 1'b0, g);
    endtask

    // R4: bypass passes data and freezes history.
    task automatic t_bypass_r4();
        logic [7:0] g;
        do_reset();
        step("R3 pre bypass", 1'b1, 8'h21, 1'b1, 1'b0, g);
        step("R4 bypass", 1'b1, 8'hE7, 1'b0, 1'b0, g);
        check("R4 raw", {24'd0, g}, 32'hE7);
        step("R4 bypass", 1'b1, 8'h0F, 1'b0, 1'b1, g);
        check("R4 raw", {24'd0, g}, 32'h0F);
        step("R4 resume", 1'b1, 8'h21, 1'b1, 1'b0, g);
        step("R4 resume", 1'b1, 8'hB0, 1'b1, 1'b0, g);
    endtask

    // R6/R7: loopback from reset restores every octet.
    task automatic t_loop_r7();
        logic [7:0] g;
        do_reset();
        for (int i = 0; i < 12; i++) begin
            orig[i] = 8'(i * 37 + 11) ^ 8'h5C;
            step("R3 loop tx", 1'b1, orig[i], 1'b1, 1'b0, cap[i]);
        end
        do_reset();
        for (int i = 0; i < 12; i++) begin
            step("R6 descramble", 1'b1, cap[i], 1'b1, 1'b1, g);
            check("R7 loopback", {24'd0, g}, {24'd0, orig[i]});
        end
    endtask

    // R7: from an arbitrary history the descrambler locks after 15 bits.
    task automatic t_selfsync_r7();
        logic [7:0] g;
        step("R6 stir", 1'b1, 8'h9D, 1'b1, 1'b1, g);
        step("R3 stir", 1'b1, 8'h42, 1'b1, 1'b0, g);
        step("R3 stir", 1'b1, 8'hF1, 1'b1, 1'b0, g);
        for (int i = 0; i < 12; i++) begin
            step("R6 resync", 1'b1, cap[i], 1'b1, 1'b1, g);
            if (i >= 2) check("R7 self sync", {24'd0, g}, {24'd0, orig[i]});
        end
    endtask

    initial begin
        #(5ns * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_seed_r1();
        t_scramble_r3();
        t_idle_r5();
        t_bypass_r4();
        t_loop_r7();
        t_selfsync_r7();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule